// File: doc/BRIEF.md
# Shared-Memory Mailbox Register Channel

This block is a register-mapped mailbox through which a host-side function and one peer, such as a virtual function or an embedded firmware core, swap short messages. Each side has its own single-cycle register port. Both ports see a shared window made of two 32-bit counter words and a fourteen-word message area. The host port also has a control register, an interrupt vector register and an interrupt mask register. The peer port has its own control register.

Each counter word packs two free-running 16-bit halves: a request count in bits 15:0 and an acknowledge count in bits 31:16. Software on each side increments its own halves with read-modify-write accesses and compares the other side's word against the values it last saw. The message area is guarded by exclusive ownership. A side claims it by writing its claim bit and then reads the bit back to learn whether the claim was accepted.

A host request write sends a one-cycle interrupt pulse to the peer when the peer has enabled it. A change in the peer's request count sends a one-cycle interrupt pulse to the host, tagged with the programmed vector, unless the host has masked it.

Top module: `mbx_channel`

## Requirements
- R1: After reset, every register and window word reads 0 from both ports, and both interrupt outputs are low.
- R2: The host-to-peer counter word at byte offset 0x00 is writable only from the host port, and the peer-to-host counter word at 0x04 only from the peer port. Both ports can read both words, and a write to the other side's word is ignored.
- R3: In a counter word, bits 15:0 are the request count and bits 31:16 are the acknowledge count. A peer write that changes only bits 31:16 of word 0x04 raises no host interrupt.
- R4: When the peer does not hold the buffer, a host write to the host control register (0x40) with bit 3 set claims the buffer. Bit 3 then reads back as 1 on the host control register and on bit 3 of the peer control register (peer 0x40).
- R5: Ownership is exclusive. A host claim made while the peer holds the buffer reads back 0. A peer claim (peer 0x40 bit 0) made while the host owns the buffer reads back 0 in peer bit 0.
- R6: Any host control write with bit 3 clear releases host ownership. Any peer control write with bit 0 clear releases the peer hold.
- R7: The message area is 14 words at byte offsets 0x08 to 0x3C and is readable from both ports at any time. A host write there takes effect only while the host owns the buffer. A peer write there takes effect only while the peer holds it.
- R8: Host control bit 0 is the request bit. It is write-only and always reads 0. Writing it as 1 drives `peer_irq` high for exactly the next cycle if peer control bit 1 (interrupt enable) is set, and not at all otherwise.
- R9: A peer write to 0x04 that changes bits 15:0 drives `host_irq` high for exactly the next cycle, with `host_irq_vec` equal to the vector register (host 0x44, bits VEC_W-1:0). This happens only while mask bit 0 at host 0x48 is 0. Rewriting the same value raises nothing.
- R10: Reads of unmapped or misaligned offsets return 0. Unmapped host offsets are 0x4C and above; unmapped peer offsets are 0x44 and above.
- R11: When the host and the peer both claim a free buffer in the same cycle, the host wins and the peer claim is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data (combinational from h_addr) |
| p_wr | input | 1 | Peer write strobe |
| p_addr | input | ADDR_W | Peer byte address |
| p_wdata | input | 32 | Peer write data |
| p_rdata | output | 32 | Peer read data (combinational from p_addr) |
| peer_irq | output | 1 | One-cycle request pulse toward the peer |
| host_irq | output | 1 | One-cycle pulse toward the host |
| host_irq_vec | output | VEC_W | Vector number carried by host_irq |

## Verification
A wrong ownership state shows on the very next read of either control register. It also shows when a data write that should have been blocked appears, or one that should have landed does not, in the following read of the message area from the other port. A wrong previous-count comparison shows as a missing or extra `host_irq` pulse in the cycle after the peer write. A wrong request or enable path shows in the same way on `peer_irq`. Every such fault therefore appears within one or two cycles of the stimulus.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned CNT_HALF_W   = 16;
  localparam int unsigned H_REQ_BIT    = 0;
  localparam int unsigned H_OWN_BIT    = 3;
  localparam int unsigned P_HOLD_BIT   = 0;
  localparam int unsigned P_IRQEN_BIT  = 1;

  // request half of a packed counter word
  function automatic logic [CNT_HALF_W-1:0] req_half(input logic [WORD_W-1:0] w);
    return w[CNT_HALF_W-1:0];
  endfunction

  // true when a new counter word moves the request half
  function automatic logic req_moved(input logic [WORD_W-1:0] old_w,
                                     input logic [WORD_W-1:0] new_w);
    return req_half(old_w) != req_half(new_w);
  endfunction

  // ownership after a control write: claim granted only if the other side is free
  function automatic logic own_next(input logic wr, input logic claim,
                                    input logic blocked, input logic cur);
    return wr ? (claim & ~blocked) : cur;
  endfunction
endpackage

// File: rtl/mbx_window.sv
module mbx_window #(
  parameter int unsigned DATA_WORDS = 14,
  parameter int unsigned DIDX_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_cnt_we,
  input  logic              p_cnt_we,
  input  logic              h_dat_we,
  input  logic              p_dat_we,
  input  logic [DIDX_W-1:0] h_idx,
  input  logic [DIDX_W-1:0] p_idx,
  input  logic [31:0]       h_wdata,
  input  logic [31:0]       p_wdata,
  output logic [31:0]       h2p_word,
  output logic [31:0]       p2h_word,
  output logic [31:0]       h_dat_rdata,
  output logic [31:0]       p_dat_rdata,
  output logic              p2h_req_evt
);
  logic [31:0] h2p_q, p2h_q;
  logic [31:0] mem [DATA_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h2p_q <= '0;
      p2h_q <= '0;
    end else begin
      if (h_cnt_we) h2p_q <= h_wdata;
      if (p_cnt_we) p2h_q <= p_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DATA_WORDS); i++) mem[i] <= '0;
    end else if (h_dat_we) begin
      mem[h_idx] <= h_wdata;
    end else if (p_dat_we) begin
      mem[p_idx] <= p_wdata;
    end
  end

  assign h2p_word    = h2p_q;
  assign p2h_word    = p2h_q;
  assign h_dat_rdata = (32'(h_idx) < DATA_WORDS) ? mem[h_idx] : '0;
  assign p_dat_rdata = (32'(p_idx) < DATA_WORDS) ? mem[p_idx] : '0;
  assign p2h_req_evt = p_cnt_we && mbx_pkg::req_moved(p2h_q, p_wdata);

  // R2
  h2p_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !h_cnt_we |=> $stable(h2p_q));
  // R2
  p2h_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !p_cnt_we |=> $stable(p2h_q));
endmodule

// File: rtl/mbx_own_ctrl.sv
module mbx_own_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic h_ctrl_we,
  input  logic h_claim_bit,
  input  logic h_req_bit,
  input  logic p_ctrl_we,
  input  logic p_hold_bit,
  input  logic p_en_bit,
  output logic host_own,
  output logic peer_hold,
  output logic peer_irq_en,
  output logic req_evt
);
  logic host_own_q, peer_hold_q, irq_en_q;
  logic host_claim, peer_claim, host_grant;

  assign host_claim = h_ctrl_we & h_claim_bit;
  assign peer_claim = p_ctrl_we & p_hold_bit;
  assign host_grant = host_claim & ~peer_hold_q;
  assign req_evt    = h_ctrl_we & h_req_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_own_q  <= 1'b0;
      peer_hold_q <= 1'b0;
      irq_en_q    <= 1'b0;
    end else begin
      host_own_q  <= mbx_pkg::own_next(h_ctrl_we, h_claim_bit, peer_hold_q, host_own_q);
      peer_hold_q <= mbx_pkg::own_next(p_ctrl_we, p_hold_bit,
                                       host_own_q | host_grant, peer_hold_q);
      if (p_ctrl_we) irq_en_q <= p_en_bit;
    end
  end

  assign host_own    = host_own_q;
  assign peer_hold   = peer_hold_q;
  assign peer_irq_en = irq_en_q;

  // R5
  own_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_own_q && peer_hold_q));
  // R5
  host_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_claim && peer_hold_q) |=> !host_own_q);
  // R6
  host_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ctrl_we && !h_claim_bit) |=> !host_own_q);
  // R11
  tie_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_claim && peer_claim && !peer_hold_q) |=> (host_own_q && !peer_hold_q));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_vec_we,
  input  logic             h_mask_we,
  input  logic [VEC_W-1:0] vec_wdata,
  input  logic             mask_wdata,
  input  logic             req_evt,
  input  logic             peer_irq_en,
  input  logic             p2h_req_evt,
  output logic             peer_irq,
  output logic             host_irq,
  output logic [VEC_W-1:0] host_vec,
  output logic             host_mask
);
  logic [VEC_W-1:0] vec_q;
  logic             mask_q, peer_irq_q, host_irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q      <= '0;
      mask_q     <= 1'b0;
      peer_irq_q <= 1'b0;
      host_irq_q <= 1'b0;
    end else begin
      if (h_vec_we)  vec_q  <= vec_wdata;
      if (h_mask_we) mask_q <= mask_wdata;
      peer_irq_q <= req_evt & peer_irq_en;
      host_irq_q <= p2h_req_evt & ~mask_q;
    end
  end

  assign peer_irq  = peer_irq_q;
  assign host_irq  = host_irq_q;
  assign host_vec  = vec_q;
  assign host_mask = mask_q;

  // R8
  peer_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peer_irq_q |-> ($past(req_evt) && $past(peer_irq_en)));
  // R9
  host_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq_q |-> ($past(p2h_req_evt) && !$past(mask_q)));
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned DATA_WORDS = 14,
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned VEC_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  input  logic              p_wr,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [31:0]       p_wdata,
  output logic [31:0]       p_rdata,
  output logic              peer_irq,
  output logic              host_irq,
  output logic [VEC_W-1:0]  host_irq_vec
);
  import mbx_pkg::*;

  localparam int unsigned WIDX_W    = ADDR_W - 2;
  localparam int unsigned DIDX_W    = $clog2(DATA_WORDS);
  localparam int unsigned WIN_WORDS = DATA_WORDS + 2;
  localparam logic [WIDX_W-1:0] W_H2P  = WIDX_W'(0);
  localparam logic [WIDX_W-1:0] W_P2H  = WIDX_W'(1);
  localparam logic [WIDX_W-1:0] W_DAT0 = WIDX_W'(2);
  localparam logic [WIDX_W-1:0] W_END  = WIDX_W'(WIN_WORDS);
  localparam logic [WIDX_W-1:0] W_CTRL = WIDX_W'(WIN_WORDS);
  localparam logic [WIDX_W-1:0] W_VEC  = WIDX_W'(WIN_WORDS + 1);
  localparam logic [WIDX_W-1:0] W_MASK = WIDX_W'(WIN_WORDS + 2);

  logic [WIDX_W-1:0] h_word, p_word;
  logic              h_align, p_align, h_in_dat, p_in_dat;
  logic [DIDX_W-1:0] h_idx, p_idx;
  logic [WIDX_W-1:0] h_off, p_off;

  assign h_word   = h_addr[ADDR_W-1:2];
  assign p_word   = p_addr[ADDR_W-1:2];
  assign h_align  = (h_addr[1:0] == 2'b00);
  assign p_align  = (p_addr[1:0] == 2'b00);
  assign h_in_dat = h_align && (h_word >= W_DAT0) && (h_word < W_END);
  assign p_in_dat = p_align && (p_word >= W_DAT0) && (p_word < W_END);
  assign h_off    = h_word - W_DAT0;
  assign p_off    = p_word - W_DAT0;
  assign h_idx    = h_off[DIDX_W-1:0];
  assign p_idx    = p_off[DIDX_W-1:0];

  logic h_sel_ctrl, h_sel_vec, h_sel_mask, p_sel_ctrl;
  assign h_sel_ctrl = h_align && (h_word == W_CTRL);
  assign h_sel_vec  = h_align && (h_word == W_VEC);
  assign h_sel_mask = h_align && (h_word == W_MASK);
  assign p_sel_ctrl = p_align && (p_word == W_CTRL);

  logic        host_own, peer_hold, peer_irq_en, req_evt, p2h_req_evt, host_mask;
  logic [31:0] h2p_word, p2h_word, h_dat_rdata, p_dat_rdata;

  mbx_window #(.DATA_WORDS(DATA_WORDS), .DIDX_W(DIDX_W)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_cnt_we   (h_wr && h_align && (h_word == W_H2P)),
    .p_cnt_we   (p_wr && p_align && (p_word == W_P2H)),
    .h_dat_we   (h_wr && h_in_dat && host_own),
    .p_dat_we   (p_wr && p_in_dat && peer_hold),
    .h_idx      (h_idx),
    .p_idx      (p_idx),
    .h_wdata    (h_wdata),
    .p_wdata    (p_wdata),
    .h2p_word   (h2p_word),
    .p2h_word   (p2h_word),
    .h_dat_rdata(h_dat_rdata),
    .p_dat_rdata(p_dat_rdata),
    .p2h_req_evt(p2h_req_evt)
  );

  mbx_own_ctrl u_own (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_ctrl_we  (h_wr && h_sel_ctrl),
    .h_claim_bit(h_wdata[H_OWN_BIT]),
    .h_req_bit  (h_wdata[H_REQ_BIT]),
    .p_ctrl_we  (p_wr && p_sel_ctrl),
    .p_hold_bit (p_wdata[P_HOLD_BIT]),
    .p_en_bit   (p_wdata[P_IRQEN_BIT]),
    .host_own   (host_own),
    .peer_hold  (peer_hold),
    .peer_irq_en(peer_irq_en),
    .req_evt    (req_evt)
  );

  mbx_irq #(.VEC_W(VEC_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_vec_we   (h_wr && h_sel_vec),
    .h_mask_we  (h_wr && h_sel_mask),
    .vec_wdata  (h_wdata[VEC_W-1:0]),
    .mask_wdata (h_wdata[0]),
    .req_evt    (req_evt),
    .peer_irq_en(peer_irq_en),
    .p2h_req_evt(p2h_req_evt),
    .peer_irq   (peer_irq),
    .host_irq   (host_irq),
    .host_vec   (host_irq_vec),
    .host_mask  (host_mask)
  );

  always_comb begin
    h_rdata = '0;
    if (h_align && h_word == W_H2P)      h_rdata = h2p_word;
    else if (h_align && h_word == W_P2H) h_rdata = p2h_word;
    else if (h_in_dat)                   h_rdata = h_dat_rdata;
    else if (h_sel_ctrl)                 h_rdata[H_OWN_BIT] = host_own;
    else if (h_sel_vec)                  h_rdata[VEC_W-1:0] = host_irq_vec;
    else if (h_sel_mask)                 h_rdata[0] = host_mask;
  end

  always_comb begin
    p_rdata = '0;
    if (p_align && p_word == W_H2P)      p_rdata = h2p_word;
    else if (p_align && p_word == W_P2H) p_rdata = p2h_word;
    else if (p_in_dat)                   p_rdata = p_dat_rdata;
    else if (p_sel_ctrl) begin
      p_rdata[H_OWN_BIT]   = host_own;
      p_rdata[P_IRQEN_BIT] = peer_irq_en;
      p_rdata[P_HOLD_BIT]  = peer_hold;
    end
  end

  // R7
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_in_dat && !host_own && !(p_wr && p_in_dat && peer_hold))
      |=> $stable(h_dat_rdata) || !$stable(h_addr));
endmodule

// File: tb/test_mbx_channel.sv
module test_mbx_channel;
  localparam int ADDR_W = 7;
  localparam int VEC_W  = 8;
  localparam int NVEC   = 38;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              h_wr = 1'b0, p_wr = 1'b0;
  logic [ADDR_W-1:0] h_addr = '0, p_addr = '0;
  logic [31:0]       h_wdata = '0, p_wdata = '0;
  logic [31:0]       h_rdata, p_rdata;
  logic              peer_irq, host_irq;
  logic [VEC_W-1:0]  host_irq_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mbx_channel #(.DATA_WORDS(14), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) i_mbx_channel (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .p_wr(p_wr), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .peer_irq(peer_irq), .host_irq(host_irq), .host_irq_vec(host_irq_vec)
  );

  // {port(0 host,1 peer), op(0 write,1 check), req, addr, wdata, expected}
  localparam logic [77:0] TBL [NVEC] = '{
    // R4 claim and read back from both sides
    {1'b0,1'b0,4'd4, 8'h40,32'h8,32'h0},
    {1'b0,1'b1,4'd4, 8'h40,32'h0,32'h8},
    {1'b1,1'b1,4'd4, 8'h40,32'h0,32'h8},
    // R7 owner writes land, non-owner writes ignored
    {1'b0,1'b0,4'd7, 8'h08,32'hA5A50001,32'h0},
    {1'b0,1'b0,4'd7, 8'h3C,32'h12345678,32'h0},
    {1'b1,1'b1,4'd7, 8'h08,32'h0,32'hA5A50001},
    {1'b1,1'b1,4'd7, 8'h3C,32'h0,32'h12345678},
    {1'b1,1'b0,4'd7, 8'h08,32'h0000DEAD,32'h0},
    {1'b0,1'b1,4'd7, 8'h08,32'h0,32'hA5A50001},
    // R2 counter words
    {1'b0,1'b0,4'd2, 8'h00,32'h00030007,32'h0},
    {1'b1,1'b1,4'd2, 8'h00,32'h0,32'h00030007},
    {1'b1,1'b0,4'd2, 8'h00,32'hFFFFFFFF,32'h0},
    {1'b0,1'b1,4'd2, 8'h00,32'h0,32'h00030007},
    {1'b0,1'b0,4'd2, 8'h04,32'h00005555,32'h0},
    {1'b0,1'b1,4'd2, 8'h04,32'h0,32'h0},
    // R6 release
    {1'b0,1'b0,4'd6, 8'h40,32'h0,32'h0},
    {1'b0,1'b1,4'd6, 8'h40,32'h0,32'h0},
    // R5 host claim rejected while peer holds
    {1'b1,1'b0,4'd5, 8'h40,32'h1,32'h0},
    {1'b1,1'b1,4'd5, 8'h40,32'h0,32'h1},
    {1'b0,1'b0,4'd5, 8'h40,32'h8,32'h0},
    {1'b0,1'b1,4'd5, 8'h40,32'h0,32'h0},
    // R7 peer owner writes, host non-owner ignored
    {1'b1,1'b0,4'd7, 8'h08,32'hCAFEF00D,32'h0},
    {1'b0,1'b1,4'd7, 8'h08,32'h0,32'hCAFEF00D},
    {1'b0,1'b0,4'd7, 8'h0C,32'h00001111,32'h0},
    {1'b1,1'b1,4'd7, 8'h0C,32'h0,32'h0},
    // R6 peer release
    {1'b1,1'b0,4'd6, 8'h40,32'h0,32'h0},
    {1'b1,1'b1,4'd6, 8'h40,32'h0,32'h0},
    // R5 peer claim rejected while host owns
    {1'b0,1'b0,4'd5, 8'h40,32'h8,32'h0},
    {1'b1,1'b0,4'd5, 8'h40,32'h1,32'h0},
    {1'b1,1'b1,4'd5, 8'h40,32'h0,32'h8},
    // R8 request bit reads 0
    {1'b0,1'b0,4'd8, 8'h40,32'h9,32'h0},
    {1'b0,1'b1,4'd8, 8'h40,32'h0,32'h8},
    {1'b0,1'b0,4'd6, 8'h40,32'h0,32'h0},
    // R10 unmapped reads
    {1'b0,1'b1,4'd10,8'h4C,32'h0,32'h0},
    {1'b1,1'b1,4'd10,8'h44,32'h0,32'h0},
    // R9 vector register
    {1'b0,1'b0,4'd9, 8'h44,32'h5A,32'h0},
    {1'b0,1'b1,4'd9, 8'h44,32'h0,32'h5A},
    {1'b0,1'b1,4'd10,8'h7C,32'h0,32'h0}
  };

  function automatic void check(input int req, input string what,
                                input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endfunction

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    h_wr = 1'b1; h_addr = a[ADDR_W-1:0]; h_wdata = d;
    @(negedge clk);
    h_wr = 1'b0;
  endtask

  task automatic peer_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    p_wr = 1'b1; p_addr = a[ADDR_W-1:0]; p_wdata = d;
    @(negedge clk);
    p_wr = 1'b0;
  endtask

  task automatic host_chk(input int req, input logic [7:0] a, input logic [31:0] e);
    @(negedge clk);
    h_addr = a[ADDR_W-1:0];
    #1;
    check(req, $sformatf("host read %h", a), h_rdata, e);
  endtask

  task automatic peer_chk(input int req, input logic [7:0] a, input logic [31:0] e);
    @(negedge clk);
    p_addr = a[ADDR_W-1:0];
    #1;
    check(req, $sformatf("peer read %h", a), p_rdata, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    host_chk(1, 8'h00, 32'h0);
    host_chk(1, 8'h04, 32'h0);
    host_chk(1, 8'h08, 32'h0);
    host_chk(1, 8'h40, 32'h0);
    host_chk(1, 8'h44, 32'h0);
    host_chk(1, 8'h48, 32'h0);
    peer_chk(1, 8'h40, 32'h0);
    check(1, "peer_irq after reset", 32'(peer_irq), 32'h0);
    check(1, "host_irq after reset", 32'(host_irq), 32'h0);

    for (int k = 0; k < NVEC; k++) begin
      logic [77:0] v;
      v = TBL[k];
      if (v[76]) begin
        if (v[77]) peer_chk(int'(v[75:72]), v[71:64], v[31:0]);
        else       host_chk(int'(v[75:72]), v[71:64], v[31:0]);
      end else begin
        if (v[77]) peer_wr(v[71:64], v[63:32]);
        else       host_wr(v[71:64], v[63:32]);
      end
    end

    // R8 request pulse with peer enable set
    peer_wr(8'h40, 32'h2);
    host_wr(8'h40, 32'h1);
    check(8, "peer_irq pulse", 32'(peer_irq), 32'h1);
    @(negedge clk);
    check(8, "peer_irq one cycle", 32'(peer_irq), 32'h0);
    // R8 request with enable clear
    peer_wr(8'h40, 32'h0);
    host_wr(8'h40, 32'h1);
    check(8, "peer_irq disabled", 32'(peer_irq), 32'h0);

    // R9 host interrupt on request change
    peer_wr(8'h04, 32'h00000001);
    check(9, "host_irq pulse", 32'(host_irq), 32'h1);
    check(9, "host_irq_vec", 32'(host_irq_vec), 32'h5A);
    @(negedge clk);
    check(9, "host_irq one cycle", 32'(host_irq), 32'h0);
    // R3 acknowledge-only change
    peer_wr(8'h04, 32'h00050001);
    check(3, "host_irq on ack change", 32'(host_irq), 32'h0);
    host_chk(3, 8'h04, 32'h00050001);
    // R9 same value rewrite
    peer_wr(8'h04, 32'h00050001);
    check(9, "host_irq on same value", 32'(host_irq), 32'h0);
    // R9 masked
    host_wr(8'h48, 32'h1);
    peer_wr(8'h04, 32'h00050002);
    check(9, "host_irq masked", 32'(host_irq), 32'h0);
    host_wr(8'h48, 32'h0);
    peer_wr(8'h04, 32'h00050003);
    check(9, "host_irq unmasked", 32'(host_irq), 32'h1);

    // R11 simultaneous claim
    @(negedge clk);
    h_wr = 1'b1; h_addr = 7'h40; h_wdata = 32'h8;
    p_wr = 1'b1; p_addr = 7'h40; p_wdata = 32'h1;
    @(negedge clk);
    h_wr = 1'b0; p_wr = 1'b0;
    host_chk(11, 8'h40, 32'h8);
    peer_chk(11, 8'h40, 32'h8);

    // R10 misaligned read
    host_chk(10, 8'h41, 32'h0);

    finish_run();
  end
endmodule